// File: doc/BRIEF.md
# Synthesizer Divider Programming Port

This block is a three-wire serial slave that loads division ratios into a frequency synthesizer's counters. A host shifts a word in on a data line, one bit for each rising edge of a serial clock, most significant bit first. It then raises a load strobe. The last bit shifted, which ends up in the least significant position, is a control bit. That bit says whether the word holds the reference-divider settings or the main-counter settings.

All three serial lines are asynchronous to the system clock. Each one passes through a two-stage synchronizer, and edges on the serial clock and the strobe are detected in the system clock domain. One shift register serves both word layouts. On the strobe, the number of bits received is compared with the length that the control bit calls for. A word of the right length is copied in one step into the register it selects. A word of the wrong length is dropped, and an error flag is raised.

Top module: `synth_prog_if`

## Requirements
- R1: The least significant bit of a word (the last bit shifted) is the control bit: 1 selects the reference word and 0 selects the main-counter word.
- R2: A reference word is 16 bits long. Bits 14:1 give the reference divide value on ref_div_o, and bit 15 gives the prescaler select on presc_sel_o.
- R3: A main-counter word is 19 bits long. Bits 7:1 give the swallow count on swallow_o, and bits 18:8 give the main divide value on main_div_o.
- R4: Bits are taken most significant first, one on each rising edge of ser_clk_i. Falling edges shift nothing.
- R5: Shifting alone never changes any output. The outputs change only on a rising edge of ser_load_i.
- R6: A valid strobe updates only the register its control bit selects. The other register keeps its value.
- R7: On a strobe, if the bit count differs from the length implied by the control bit, the word is discarded, both registers hold, and len_err_o is set. A later valid strobe clears len_err_o.
- R8: A rising edge of ser_load_i restarts the bit count, so a word that follows a bad word is accepted when it is complete.
- R9: After reset, every divider output and len_err_o are zero.
- R10: The update becomes visible on the outputs no later than 4 clk_i cycles after the strobe's rising edge arrives at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_data_i | input | 1 | Serial data (asynchronous) |
| ser_load_i | input | 1 | Load strobe (asynchronous) |
| ref_div_o | output | 14 | Latched reference divide value |
| presc_sel_o | output | 1 | Latched prescaler select |
| swallow_o | output | 7 | Latched swallow count |
| main_div_o | output | 11 | Latched main divide value |
| len_err_o | output | 1 | Last strobe saw a word of the wrong length |

## Verification
A pin transition needs two synchronizer stages and one edge-detect stage before it reaches the latch, so a strobe shows on the outputs about three clk_i edges after it arrives. The bench holds every serial phase for four system cycles, which gives each data bit time to settle ahead of its shift edge. It reads the outputs six cycles after the strobe is released, at the falling edge of clk_i, so the update has already landed. The no-change checks are read at that same point, after a complete shift and before any strobe, so any early or wrong update would already show.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  parameter int R_W   = 14;
  parameter int A_W   = 7;
  parameter int N_W   = 11;
  parameter int SYN_N = 2;
  localparam int REF_LEN  = R_W + 2;
  localparam int MAIN_LEN = A_W + N_W + 1;
  localparam int SR_W     = (REF_LEN > MAIN_LEN) ? REF_LEN : MAIN_LEN;
  localparam int CNT_W    = $clog2(SR_W + 2);
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int W = 3,
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < N; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[N-1];
endmodule

// File: rtl/sp_edge.sv
module sp_edge #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_rise
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/sp_shift.sv
module sp_shift
  import synth_prog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             restart_i,
  input  logic             bit_i,
  output logic [SR_W-1:0]  sr_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(SR_W + 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_o  <= '0;
      cnt_o <= '0;
    end else if (restart_i) begin
      cnt_o <= '0;
    end else if (shift_i) begin
      sr_o <= {sr_o[SR_W-2:0], bit_i};
      if (cnt_o != CNT_CAP) cnt_o <= cnt_o + 1'b1;
    end
  end

  p_cnt_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_o == '0));

  p_shift_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !restart_i) |=> (sr_o[0] == $past(bit_i)));

  p_no_shift_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(sr_o));
endmodule

// File: rtl/sp_latch.sv
module sp_latch
  import synth_prog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [SR_W-1:0]  sr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [R_W-1:0]   ref_div_o,
  output logic             presc_sel_o,
  output logic [A_W-1:0]   swallow_o,
  output logic [N_W-1:0]   main_div_o,
  output logic             len_err_o
);
  logic ctl, ref_ok, main_ok;

  assign ctl     = sr_i[0];
  assign ref_ok  = ctl  && (cnt_i == CNT_W'(REF_LEN));
  assign main_ok = !ctl && (cnt_i == CNT_W'(MAIN_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_div_o   <= '0;
      presc_sel_o <= 1'b0;
      swallow_o   <= '0;
      main_div_o  <= '0;
      len_err_o   <= 1'b0;
    end else if (strobe_i) begin
      len_err_o <= !(ref_ok || main_ok);
      if (ref_ok) begin
        ref_div_o   <= sr_i[R_W:1];
        presc_sel_o <= sr_i[R_W+1];
      end
      if (main_ok) begin
        swallow_o  <= sr_i[A_W:1];
        main_div_o <= sr_i[A_W+N_W:A_W+1];
      end
    end
  end

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> ($stable(ref_div_o) && $stable(swallow_o) &&
                   $stable(main_div_o) && $stable(presc_sel_o)));

  p_sel_ref_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && ctl) |=> ($stable(swallow_o) && $stable(main_div_o)));

  p_sel_main_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !ctl) |=> ($stable(ref_div_o) && $stable(presc_sel_o)));

  p_len_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && ctl && cnt_i != CNT_W'(REF_LEN)) |=> len_err_o);
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ser_clk_i,
  input  logic           ser_data_i,
  input  logic           ser_load_i,
  output logic [R_W-1:0] ref_div_o,
  output logic           presc_sel_o,
  output logic [A_W-1:0] swallow_o,
  output logic [N_W-1:0] main_div_o,
  output logic           len_err_o
);
  logic [2:0]       pins_s;
  logic [1:0]       rise;
  logic [SR_W-1:0]  sr;
  logic [CNT_W-1:0] cnt;

  // bit0 clock, bit1 load, bit2 data: equal latency keeps data aligned to clock
  sp_sync #(.W(3), .N(SYN_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ser_data_i, ser_load_i, ser_clk_i}),
    .q_o   (pins_s)
  );

  sp_edge #(.W(2)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pins_s[1:0]),
    .rise_o(rise)
  );

  sp_shift u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .shift_i  (rise[0]),
    .restart_i(rise[1]),
    .bit_i    (pins_s[2]),
    .sr_o     (sr),
    .cnt_o    (cnt)
  );

  sp_latch u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (rise[1]),
    .sr_i       (sr),
    .cnt_i      (cnt),
    .ref_div_o  (ref_div_o),
    .presc_sel_o(presc_sel_o),
    .swallow_o  (swallow_o),
    .main_div_o (main_div_o),
    .len_err_o  (len_err_o)
  );
endmodule

// File: tb/synth_prog_if_bench.sv
module synth_prog_if_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, sld = 1'b0;
  logic [13:0] ref_div;
  logic        presc;
  logic [6:0]  swal;
  logic [10:0] mdiv;
  logic        err;
  int vec = 0, bad = 0;
  bit done = 0;

  // expected model
  logic [13:0] e_ref = '0;
  logic        e_presc = 1'b0;
  logic [6:0]  e_swal = '0;
  logic [10:0] e_mdiv = '0;
  logic        e_err = 1'b0;

  always #5 clk = ~clk;

  synth_prog_if u_synth_prog_if (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_data_i(sdat),
    .ser_load_i(sld), .ref_div_o(ref_div), .presc_sel_o(presc),
    .swallow_o(swal), .main_div_o(mdiv), .len_err_o(err)
  );

  task automatic wait_clk(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, 64'(ref_div), 64'(e_ref));
    chk(req, 64'(presc), 64'(e_presc));
    chk(req, 64'(swal), 64'(e_swal));
    chk(req, 64'(mdiv), 64'(e_mdiv));
    chk(req, 64'(err), 64'(e_err));
  endtask

  // shift n bits, MSB first; a falling edge of sclk follows each rise
  task automatic shift(logic [31:0] w, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = w[i];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
      sdat = ~w[i];
      wait_clk(4);
    end
  endtask

  task automatic strobe();
    sld = 1'b1;
    wait_clk(4);
    sld = 1'b0;
    wait_clk(6);
  endtask

  function automatic logic [31:0] ref_word(logic [13:0] r, logic p);
    return {16'd0, p, r, 1'b1};
  endfunction

  function automatic logic [31:0] main_word(logic [6:0] a, logic [10:0] n);
    return {13'd0, n, a, 1'b0};
  endfunction

  task automatic t_reset();
    check_all("R9");
  endtask

  task automatic t_ref_load();
    shift(ref_word(14'h2A5B, 1'b1), 16);
    check_all("R5 shift-only");
    strobe();
    e_ref = 14'h2A5B; e_presc = 1'b1;
    check_all("R1/R2 ref word");
  endtask

  task automatic t_main_load();
    shift(main_word(7'h55, 11'h4C3), 19);
    check_all("R5 shift-only main");
    strobe();
    e_swal = 7'h55; e_mdiv = 11'h4C3;
    check_all("R3/R6 main word, ref held");
  endtask

  task automatic t_ref_again();
    shift(ref_word(14'h1234, 1'b0), 16);
    strobe();
    e_ref = 14'h1234; e_presc = 1'b0;
    check_all("R6 ref update, main held");
  endtask

  task automatic t_latency();
    shift(main_word(7'h0F, 11'h7FF), 19);
    sld = 1'b1;
    wait_clk(4);
    e_swal = 7'h0F; e_mdiv = 11'h7FF;
    check_all("R10 latency");
    sld = 1'b0;
    wait_clk(6);
  endtask

  task automatic t_short_word();
    shift(ref_word(14'h3FFF, 1'b1), 15);
    strobe();
    e_err = 1'b1;
    check_all("R7 short ref word");
  endtask

  task automatic t_long_word();
    shift({11'd0, 7'h7F, 1'b0, 1'b0}, 20);
    strobe();
    check_all("R7 long main word");
  endtask

  task automatic t_wrong_type();
    // 16 bits with control bit 0: length mismatch for main layout
    shift(32'h0000_ABCE, 16);
    strobe();
    check_all("R7/R1 ref-length word with main control bit");
  endtask

  task automatic t_restart();
    shift(32'h5, 3);
    strobe();
    check_all("R7 partial word");
    shift(main_word(7'h2A, 11'h155), 19);
    strobe();
    e_swal = 7'h2A; e_mdiv = 11'h155; e_err = 1'b0;
    check_all("R8 word after bad word / R7 clear");
  endtask

  task automatic t_bit_order();
    shift(ref_word(14'h0001, 1'b0), 16);
    strobe();
    e_ref = 14'h0001; e_presc = 1'b0;
    check_all("R4 MSB-first order low bit");
    shift(ref_word(14'h2000, 1'b1), 16);
    strobe();
    e_ref = 14'h2000; e_presc = 1'b1;
    check_all("R4 MSB-first order high bit");
  endtask

  initial begin
    wait_clk(3);
    t_reset();
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_ref_load();
    t_main_load();
    t_ref_again();
    t_latency();
    t_short_word();
    t_long_word();
    t_wrong_type();
    t_restart();
    t_bit_order();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1;
      vec++; bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule